// File: doc/BRIEF.md
# Fixed-Latency DDR Memory Transaction Sequencer

This block turns one request on a plain request port into a complete single-word transaction on an eight-bit double-data-rate memory bus of the HyperBus kind. The request carries a direction, a 32-bit address, a 16-bit write word and a two-bit byte mask. The block then controls everything the memory sees. It lowers the active-low select. It starts the bus clock. It shifts out a 48-bit command/address word one byte per clock edge. It waits out a fixed access latency that is doubled by default. Finally it moves one 16-bit word.

The internal clock runs at twice the bus clock, so one internal cycle stands for one bus edge. On writes the strobe line is driven by the block and acts as a byte mask. On reads the memory drives it as a data strobe, and a small sampler latches one byte on each of its transitions. A busy/done handshake serialises requests. A short select-high gap separates consecutive transactions.

Top module: `hb_fixlat_seq`

## Requirements
- R1: Out of reset and whenever idle: `cs_n`=1, `ck_en`=0, `ck`=0, `dq_oe`=0, `rwds_oe`=0, `busy`=0, `done`=0, `rd_valid`=0.
- R2: The internal cycle after a request is accepted (the lead cycle) already drives `dq_o` with command byte 0. Bus edges 0..5 then drive command bytes 0..5, with byte 0 = bits [47:40] and each following byte the next lower eight bits.
- R3: The command word has bit 47 = 1 for read and 0 for write, bit 46 = 0, and bit 45 = 1. Bits [44:16] hold address bits [31:3], bits [15:3] are zero, and bits [2:0] hold address bits [2:0].
- R4: `ck_en` is high exactly for bus edges 0..29. `ck` is 1 after even edges and 0 after odd edges, and it is 0 in all other cycles.
- R5: During latency edges 6..26, `dq_oe` and `rwds_oe` are both low. For a write, `rwds_oe` goes high with `rwds_o`=0 at edge 27.
- R6: A write drives `wdata[15:8]` at edge 28 and `wdata[7:0]` at edge 29, with `dq_oe` high.
- R7: A write drives `rwds_o` at edge 28 equal to `mask[1]` and at edge 29 equal to `mask[0]`. A 1 masks the byte.
- R8: A read never drives `rwds`, and it releases `dq` after edge 5. It latches `dq_i` on each `rwds_i` transition after the command phase. The first byte becomes `rd_data[15:8]` and the second becomes `rd_data[7:0]`. `rd_valid` pulses for one cycle together with `done`.
- R9: `busy` is high from the lead cycle through the `done` cycle. A request presented while busy is ignored, including any change to its fields.
- R10: After edge 29, `cs_n` stays high for at least 2 cycles before the block can accept again. `done` is in the second of those cycles. While `cs_n` is high, `dq`, `rwds` and the clock are released.
- R11: `cs_n` is low exactly from the lead cycle through edge 29.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock, twice the bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present; taken when idle |
| req_read | input | 1 | 1 = read, 0 = write |
| req_addr | input | 32 | Word address |
| req_wdata | input | 16 | Write word |
| req_mask | input | 2 | Byte mask, bit 1 = upper byte |
| busy | output | 1 | Transaction in flight |
| done | output | 1 | One-cycle end-of-transaction pulse |
| rd_valid | output | 1 | Read word valid pulse |
| rd_data | output | 16 | Read word |
| cs_n | output | 1 | Memory select, active low |
| ck_en | output | 1 | Bus clock running |
| ck | output | 1 | Bus clock level |
| dq_o | output | 8 | Data/command out |
| dq_oe | output | 1 | Data driver enable |
| dq_i | input | 8 | Data from memory |
| rwds_o | output | 1 | Strobe/mask out |
| rwds_oe | output | 1 | Strobe driver enable |
| rwds_i | input | 1 | Strobe from memory |

## Verification
The assertions assume a well-behaved memory on reads. It holds `rwds_i` low through the latency and then toggles it exactly twice in the data window, with one byte valid at each transition. Under that assumption a finished read always has two captured bytes. The bench memory model follows this timing for every read. Requests are driven at the falling edge, so their fields are stable at the accepting edge. A request is also held active through a whole transaction while its data changes, which exercises the ignore rule without breaking any input assumption.

// File: rtl/hb_seq_pkg.sv
package hb_seq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LEAD = 2'd1,
    ST_XFER = 2'd2,
    ST_GAP  = 2'd3
  } seq_state_t;

  localparam int CMD_W     = 48;
  localparam int CMD_EDGES = CMD_W / 8;

  // Command word: direction, space, burst type, upper/lower address.
  function automatic logic [CMD_W-1:0] make_cmd(input logic rd,
                                                input logic [31:0] addr);
    logic [CMD_W-1:0] c;
    c        = '0;
    c[47]    = rd;
    c[46]    = 1'b0;
    c[45]    = 1'b1;
    c[44:16] = addr[31:3];
    c[2:0]   = addr[2:0];
    return c;
  endfunction

  // Byte idx of the command word, most significant first.
  function automatic logic [7:0] cmd_byte(input logic [CMD_W-1:0] c,
                                          input int idx);
    return c[(CMD_W-1-8*idx) -: 8];
  endfunction

  // First data edge: latency starts at edge 4, each cycle is two edges.
  function automatic int first_data_edge(input int lat, input int mult);
    return 4 + 2 * lat * mult;
  endfunction

endpackage

// File: rtl/hb_seq_fsm.sv
module hb_seq_fsm
  import hb_seq_pkg::*;
#(
  parameter int LAST_EDGE = 29,
  parameter int CS_GAP    = 2,
  parameter int EW        = 5,
  parameter int GW        = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output seq_state_t    state,
  output logic [EW-1:0] ecnt,
  output logic          accept,
  output logic          done
);

  localparam logic [EW-1:0] LAST_E = EW'(LAST_EDGE);
  localparam logic [GW-1:0] LAST_G = GW'(CS_GAP - 1);

  logic [GW-1:0] gcnt;

  assign accept = (state == ST_IDLE) && req_valid;
  assign done   = (state == ST_GAP) && (gcnt == LAST_G);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      ecnt  <= '0;
      gcnt  <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (req_valid) state <= ST_LEAD;
        ST_LEAD: begin
          state <= ST_XFER;
          ecnt  <= '0;
        end
        ST_XFER: begin
          if (ecnt == LAST_E) begin
            state <= ST_GAP;
            gcnt  <= '0;
          end else begin
            ecnt <= ecnt + EW'(1);
          end
        end
        ST_GAP: begin
          if (gcnt == LAST_G) state <= ST_IDLE;
          else                gcnt  <= gcnt + GW'(1);
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assert_edge_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_XFER && ecnt != LAST_E) |=> (state == ST_XFER && ecnt == $past(ecnt) + EW'(1)));

  assert_lead_then_edge0_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_LEAD) |=> (state == ST_XFER && ecnt == '0));

  assert_gap_after_last_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_XFER && ecnt == LAST_E) |=> (state == ST_GAP));

endmodule

// File: rtl/hb_tx_drive.sv
module hb_tx_drive
  import hb_seq_pkg::*;
#(
  parameter int DATA_EDGE = 28,
  parameter int EW        = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  seq_state_t       state,
  input  logic [EW-1:0]    ecnt,
  input  logic             is_read,
  input  logic [CMD_W-1:0] cmd,
  input  logic [15:0]      wdata,
  input  logic [1:0]       mask,
  output logic             cs_n,
  output logic             ck_en,
  output logic             ck,
  output logic [7:0]       dq_o,
  output logic             dq_oe,
  output logic             rwds_o,
  output logic             rwds_oe
);

  localparam logic [EW-1:0] CMD_END = EW'(CMD_EDGES);
  localparam logic [EW-1:0] D_HI    = EW'(DATA_EDGE);
  localparam logic [EW-1:0] D_LO    = EW'(DATA_EDGE + 1);
  localparam logic [EW-1:0] RW_ON   = EW'(DATA_EDGE - 1);

  logic in_lead, in_xfer, in_cmd, wr_data_hi, wr_data_lo, wr_rwds_win;

  assign in_lead     = (state == ST_LEAD);
  assign in_xfer     = (state == ST_XFER);
  assign in_cmd      = in_xfer && (ecnt < CMD_END);
  assign wr_data_hi  = in_xfer && !is_read && (ecnt == D_HI);
  assign wr_data_lo  = in_xfer && !is_read && (ecnt == D_LO);
  assign wr_rwds_win = in_xfer && !is_read && (ecnt >= RW_ON);

  assign cs_n  = !(in_lead || in_xfer);
  assign ck_en = in_xfer;
  assign ck    = in_xfer && !ecnt[0];

  always_comb begin
    dq_o  = 8'h00;
    dq_oe = 1'b0;
    if (in_lead) begin
      dq_o  = cmd_byte(cmd, 0);
      dq_oe = 1'b1;
    end else if (in_cmd) begin
      dq_o  = cmd_byte(cmd, int'(ecnt));
      dq_oe = 1'b1;
    end else if (wr_data_hi) begin
      dq_o  = wdata[15:8];
      dq_oe = 1'b1;
    end else if (wr_data_lo) begin
      dq_o  = wdata[7:0];
      dq_oe = 1'b1;
    end
  end

  assign rwds_oe = wr_rwds_win;
  assign rwds_o  = (wr_data_hi && mask[1]) || (wr_data_lo && mask[0]);

  assert_no_rwds_on_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rwds_oe |-> !is_read);

  assert_ck_toggles_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ck_en && $past(ck_en)) |-> (ck != $past(ck)));

endmodule

// File: rtl/hb_rx_capture.sv
module hb_rx_capture (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clear,
  input  logic        window,
  input  logic        rwds_i,
  input  logic [7:0]  dq_i,
  output logic [15:0] rd_data,
  output logic [1:0]  nbytes
);

  logic       rwds_q;
  logic [7:0] b_hi, b_lo;
  logic       strobe;

  assign strobe  = window && (rwds_i != rwds_q) && (nbytes != 2'd2);
  assign rd_data = {b_hi, b_lo};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rwds_q <= 1'b0;
      nbytes <= '0;
      b_hi   <= '0;
      b_lo   <= '0;
    end else if (clear) begin
      rwds_q <= 1'b0;
      nbytes <= '0;
    end else if (window) begin
      rwds_q <= rwds_i;
      if (strobe) begin
        if (nbytes == 2'd0) b_hi <= dq_i;
        else                b_lo <= dq_i;
        nbytes <= nbytes + 2'd1;
      end
    end
  end

  assert_count_bounded_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (nbytes == 2'd2 && !clear) |=> (nbytes == 2'd2));

endmodule

// File: rtl/hb_fixlat_seq.sv
module hb_fixlat_seq
  import hb_seq_pkg::*;
#(
  parameter int LAT_CYC  = 6,
  parameter int LAT_MULT = 2,
  parameter int CS_GAP   = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        req_read,
  input  logic [31:0] req_addr,
  input  logic [15:0] req_wdata,
  input  logic [1:0]  req_mask,
  output logic        busy,
  output logic        done,
  output logic        rd_valid,
  output logic [15:0] rd_data,
  output logic        cs_n,
  output logic        ck_en,
  output logic        ck,
  output logic [7:0]  dq_o,
  output logic        dq_oe,
  input  logic [7:0]  dq_i,
  output logic        rwds_o,
  output logic        rwds_oe,
  input  logic        rwds_i
);

  localparam int DATA_EDGE = first_data_edge(LAT_CYC, LAT_MULT);
  localparam int LAST_EDGE = DATA_EDGE + 1;
  localparam int EW        = $clog2(LAST_EDGE + 1);
  localparam int GW        = (CS_GAP > 1) ? $clog2(CS_GAP) : 1;
  localparam logic [EW-1:0] CMD_END = EW'(CMD_EDGES);

  seq_state_t       state;
  logic [EW-1:0]    ecnt;
  logic             accept;
  logic             lat_read;
  logic [CMD_W-1:0] lat_cmd;
  logic [15:0]      lat_wdata;
  logic [1:0]       lat_mask;
  logic             rx_window;
  logic [1:0]       rx_count;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lat_read  <= 1'b0;
      lat_cmd   <= '0;
      lat_wdata <= '0;
      lat_mask  <= '0;
    end else if (accept) begin
      lat_read  <= req_read;
      lat_cmd   <= make_cmd(req_read, req_addr);
      lat_wdata <= req_wdata;
      lat_mask  <= req_mask;
    end
  end

  hb_seq_fsm #(
    .LAST_EDGE(LAST_EDGE), .CS_GAP(CS_GAP), .EW(EW), .GW(GW)
  ) fsm_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
    .state(state), .ecnt(ecnt), .accept(accept), .done(done)
  );

  hb_tx_drive #(
    .DATA_EDGE(DATA_EDGE), .EW(EW)
  ) tx_i (
    .clk(clk), .rst_n(rst_n), .state(state), .ecnt(ecnt),
    .is_read(lat_read), .cmd(lat_cmd), .wdata(lat_wdata), .mask(lat_mask),
    .cs_n(cs_n), .ck_en(ck_en), .ck(ck), .dq_o(dq_o), .dq_oe(dq_oe),
    .rwds_o(rwds_o), .rwds_oe(rwds_oe)
  );

  assign rx_window = (state == ST_XFER) && lat_read && (ecnt >= CMD_END);

  hb_rx_capture rx_i (
    .clk(clk), .rst_n(rst_n), .clear(accept), .window(rx_window),
    .rwds_i(rwds_i), .dq_i(dq_i), .rd_data(rd_data), .nbytes(rx_count)
  );

  assign busy     = (state != ST_IDLE);
  assign rd_valid = done && lat_read;

  assert_read_complete_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && lat_read) |-> (rx_count == 2'd2));

  assert_busy_ends_on_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(done));

  assert_cs_min_high_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |=> cs_n);

  assert_released_when_deselected_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> (!dq_oe && !rwds_oe && !ck_en));

  assert_no_accept_while_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);

endmodule

// File: tb/hb_fixlat_seq_tb_top.sv
`timescale 1ns/1ps
module hb_fixlat_seq_tb_top;

  localparam int LAST_PH = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_read = 1'b0;
  logic [31:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_mask = '0;
  logic        busy, done, rd_valid, cs_n, ck_en, ck, dq_oe, rwds_o, rwds_oe;
  logic [15:0] rd_data;
  logic [7:0]  dq_o;
  logic [7:0]  dq_i = '0;
  logic        rwds_i = 1'b0;

  int checks = 0, errors = 0, cyc = 0, ph = -1;
  bit finished = 0;
  logic        m_rd;
  logic [31:0] m_addr;
  logic [15:0] m_wd;
  logic [1:0]  m_mk;

  always #4 clk = ~clk;

  hb_fixlat_seq dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_read(req_read),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_mask(req_mask),
    .busy(busy), .done(done), .rd_valid(rd_valid), .rd_data(rd_data),
    .cs_n(cs_n), .ck_en(ck_en), .ck(ck), .dq_o(dq_o), .dq_oe(dq_oe),
    .dq_i(dq_i), .rwds_o(rwds_o), .rwds_oe(rwds_oe), .rwds_i(rwds_i)
  );

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s phase %0d got %h expected %h", tag, ph, got, exp);
    end
  endtask

  function automatic logic [15:0] mem_word(input logic [31:0] a);
    return a[15:0] ^ 16'hA55A;
  endfunction

  function automatic logic [7:0] cmd_b(input logic rd, input logic [31:0] a, input int k);
    logic [47:0] w;
    w = (48'(rd) << 47) | (48'h1 << 45) | (48'(a >> 3) << 16) | 48'(a & 32'h7);
    return 8'(w >> (40 - 8 * k));
  endfunction

  // Reference model: phase -1 idle, 0 lead, 1..30 edges 0..29, 31..32 gap.
  always @(posedge clk) begin
    cyc++;
    if (!rst_n) ph = -1;
    else if (ph == -1) begin
      if (req_valid) begin
        m_rd = req_read; m_addr = req_addr; m_wd = req_wdata; m_mk = req_mask;
        ph = 0;
      end
    end else if (ph == LAST_PH) ph = -1;
    else ph++;
    if (cyc > 20000 && !finished) begin
      errors++;
      $display("FAIL R9 watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      finished = 1;
      $finish;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      int e;
      e = ph - 1;
      if (ph == -1) begin
        chk("R1 cs_n idle", cs_n, 1); chk("R1 ck_en idle", ck_en, 0);
        chk("R1 ck idle", ck, 0); chk("R1 dq_oe idle", dq_oe, 0);
        chk("R1 rwds_oe idle", rwds_oe, 0); chk("R9 busy idle", busy, 0);
        chk("R1 done idle", done, 0); chk("R1 rd_valid idle", rd_valid, 0);
      end else begin
        chk("R9 busy", busy, 1);
        chk("R11 cs_n", cs_n, (ph >= 31));
        chk("R4 ck_en", ck_en, (ph >= 1 && ph <= 30));
        chk("R4 ck", ck, (ph >= 1 && ph <= 30 && (e % 2 == 0)));
        chk("R10 done", done, (ph == LAST_PH));
        chk("R8 rd_valid", rd_valid, (ph == LAST_PH && m_rd));
        if (ph == 0) begin
          chk("R2 lead dq_oe", dq_oe, 1); chk("R2 lead byte", dq_o, cmd_b(m_rd, m_addr, 0));
        end else if (e >= 0 && e <= 5) begin
          chk("R2 cmd dq_oe", dq_oe, 1);
          chk(e == 0 ? "R3 cmd byte" : "R2 cmd byte", dq_o, cmd_b(m_rd, m_addr, e));
          chk("R5 rwds_oe cmd", rwds_oe, 0);
        end else if (e >= 6 && e <= 26) begin
          chk("R5 dq released", dq_oe, 0); chk("R5 rwds released", rwds_oe, 0);
        end else if (e == 27) begin
          chk("R5 dq released 27", dq_oe, 0);
          chk("R5 rwds_oe 27", rwds_oe, !m_rd);
          if (!m_rd) chk("R5 rwds low 27", rwds_o, 0);
        end else if (e == 28 || e == 29) begin
          if (m_rd) begin
            chk("R8 dq released", dq_oe, 0); chk("R8 rwds released", rwds_oe, 0);
          end else begin
            chk("R6 dq_oe", dq_oe, 1);
            chk("R6 data byte", dq_o, (e == 28) ? m_wd[15:8] : m_wd[7:0]);
            chk("R7 rwds_oe", rwds_oe, 1);
            chk("R7 mask", rwds_o, (e == 28) ? m_mk[1] : m_mk[0]);
          end
        end else begin
          chk("R10 dq released", dq_oe, 0); chk("R10 rwds released", rwds_oe, 0);
        end
        if (ph == LAST_PH && m_rd) chk("R8 rd_data", rd_data, mem_word(m_addr));
      end
    end
    // memory model: strobe high with upper byte at edge 28, low with lower byte at 29
    if (ph == 29 && m_rd) begin rwds_i = 1'b1; dq_i = mem_word(m_addr) >> 8; end
    else if (ph == 30 && m_rd) begin rwds_i = 1'b0; dq_i = 8'(mem_word(m_addr)); end
    else begin rwds_i = 1'b0; dq_i = 8'h00; end
  end

  task automatic run(input logic rd, input logic [31:0] a, input logic [15:0] wd,
                     input logic [1:0] mk, input bit hold);
    req_valid = 1'b1; req_read = rd; req_addr = a; req_wdata = wd; req_mask = mk;
    do @(negedge clk); while (ph != 0);
    if (!hold) req_valid = 1'b0;
    else begin
      // R9: held request with changing fields must not disturb the transfer
      req_wdata = ~wd; req_mask = ~mk; req_addr = ~a; req_read = ~rd;
      do @(negedge clk); while (ph != LAST_PH);
      req_valid = 1'b0;
    end
    do @(negedge clk); while (ph != -1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset cs_n", cs_n, 1); chk("R1 reset busy", busy, 0);
    chk("R1 reset ck_en", ck_en, 0); chk("R1 reset dq_oe", dq_oe, 0);
    rst_n = 1'b1;
    @(negedge clk);
    run(1'b0, 32'h0000_1238, 16'hBEEF, 2'b00, 0);
    run(1'b0, 32'h8000_0007, 16'h1234, 2'b10, 0);
    run(1'b0, 32'h0F0F_F0F1, 16'hC3A5, 2'b01, 0);
    run(1'b0, 32'hFFFF_FFFF, 16'h00FF, 2'b11, 0);
    run(1'b1, 32'h1234_5677, 16'h0000, 2'b00, 0);
    run(1'b1, 32'hFFFF_FFF8, 16'h0000, 2'b00, 0);
    run(1'b0, 32'h0000_0000, 16'h5AA5, 2'b00, 1);
    run(1'b1, 32'h00AB_CDEF, 16'h0000, 2'b00, 1);
    run(1'b0, 32'h7654_3210, 16'h8001, 2'b10, 0);
    repeat (4) @(negedge clk);
    if (!finished) begin
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      finished = 1;
      $finish;
    end
  end

endmodule